// File: doc/BRIEF.md
# Banked and Indirect Data Address Generator

This block forms the 12-bit data-memory address for every data access of an 8-bit processor core, and it holds the registers that address generation needs: a 4-bit bank register and three 12-bit pointer registers. The decoder issues one operation per cycle on `opCode`, with `opValid` high. The block answers in the same cycle with `addrValid` and `dataAddr`. Any change to a pointer or to the bank register that the operation causes takes effect on the clock edge that ends that cycle.

A direct access combines an 8-bit file address with either the bank register or a fixed split of the low file addresses. In that split, file addresses from 0x60 upward reach the top page and the rest reach page zero. An indirect access takes its address from one pointer in one of five ways:

- the pointer value unchanged;
- the value, then the pointer is incremented;
- the value, then the pointer is decremented;
- the pointer is incremented first and the new value is used;
- the pointer plus a signed W offset.

Pointer 2 also acts as a software stack pointer. It supports frame-relative addressing with a 7-bit offset and a push of a literal that decrements it. Pointers can be loaded whole, raised or lowered by a 6-bit amount, and read back as a high byte and a low byte.

Top module: `dataAddrGen`

## Requirements
- R1: After reset all three pointers and the bank register are zero, and with `opValid` low `addrValid` is 0 and `dataAddr` is 0.
- R2: Direct access (op 1) with `bankedSel`=1 gives `dataAddr` = {bank, `fileAddr`}.
- R3: Direct access (op 1) with `bankedSel`=0 gives {4'hF, `fileAddr`} when `fileAddr` >= 0x60, otherwise {4'h0, `fileAddr`}.
- R4: Plain indirect (op 2) addresses the selected pointer and leaves it unchanged.
- R5: Post-increment (op 3) addresses the pointer value and the pointer becomes value+1. Post-decrement (op 4) addresses the value and the pointer becomes value-1.
- R6: Pre-increment (op 5) addresses value+1, and the pointer becomes value+1.
- R7: W-indexed (op 6) addresses pointer + sign-extended `wReg`, and the pointer is unchanged.
- R8: Pointer load (op 7) sets the selected pointer to `imm[11:0]`. Readback via `ptrRdSel` gives `ptrRdHi` = {4'h0, bits 11:8} and `ptrRdLo` = bits 7:0. The op drives no access.
- R9: Pointer add (op 8) and subtract (op 9) change the selected pointer by the unsigned value `imm[5:0]`. Neither op drives an access.
- R10: Stack-relative access (op 10) addresses pointer 2 + zero-extended `imm[6:0]`. It ignores `ptrSel` and leaves pointer 2 unchanged.
- R11: Push literal (op 11) addresses pointer 2 and then decrements pointer 2. It ignores `ptrSel`.
- R12: Bank load (op 12) sets the bank register to `imm[3:0]`, and `bankOut` shows it from the next cycle.
- R13: All pointer and address arithmetic wraps modulo 4096.
- R14: A pointer op with `ptrSel`=3 drives no access and changes no register. The same holds for any op with `opValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | An operation is present this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| ptrSel | input | 2 | Pointer index for pointer ops (0..2) |
| bankedSel | input | 1 | Direct access uses the bank register |
| fileAddr | input | 8 | File address for direct access |
| imm | input | 12 | Immediate: load value, adjust amount, frame offset or bank |
| wReg | input | 8 | W register, signed offset for W-indexed access |
| ptrRdSel | input | 2 | Pointer selected for readback |
| addrValid | output | 1 | `dataAddr` is a real access this cycle |
| dataAddr | output | 12 | Data-memory address |
| ptrRdHi | output | 8 | Readback high byte, zero-padded bits 11:8 |
| ptrRdLo | output | 8 | Readback low byte |
| bankOut | output | 4 | Current bank register |

## Verification
The bench probes the split between file addresses 0x5F and 0x60. A design that compared against the wrong bound, or that used the bank register in access mode, would send one of these addresses to the wrong page. It checks that the post-access ops expose the old pointer value while pre-increment exposes the new one, so swapping their timing is caught. Wrapping is checked through 0xFFF with increment, through 0x000 with subtract, and with W negative, which shows whether W is zero-extended instead of sign-extended. The bench also issues pointer ops with index 3 or with `opValid` low and then reads the pointers back. A design that still wrote a register in those cases would show up in the readback.

// File: rtl/dagPkg.sv
package dagPkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_DIRECT   = 4'd1,
    OP_IND      = 4'd2,
    OP_POSTINC  = 4'd3,
    OP_POSTDEC  = 4'd4,
    OP_PREINC   = 4'd5,
    OP_WINDEX   = 4'd6,
    OP_LDPTR    = 4'd7,
    OP_ADDPTR   = 4'd8,
    OP_SUBPTR   = 4'd9,
    OP_STKREL   = 4'd10,
    OP_PUSHLIT  = 4'd11,
    OP_LDBANK   = 4'd12
  } dagOp_e;

  typedef enum logic [1:0] {
    OFF_NONE = 2'd0,
    OFF_ONE  = 2'd1,
    OFF_W    = 2'd2,
    OFF_IMM  = 2'd3
  } offSel_e;

  typedef enum logic [2:0] {
    NX_IMM = 3'd0,
    NX_INC = 3'd1,
    NX_DEC = 3'd2,
    NX_ADD = 3'd3,
    NX_SUB = 3'd4
  } nextSel_e;

  typedef struct packed {
    logic       accEn;
    logic       directSel;
    logic [1:0] ptrIdx;
    offSel_e    offSel;
    logic       ptrWr;
    nextSel_e   nextSel;
    logic       bankWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/dagCtrl.sv
module dagCtrl
  import dagPkg::*;
#(
  parameter int NUM_PTRS  = 3,
  parameter int PTR_SEL_W = 2,
  parameter int STK_PTR   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [3:0]           opCode,
  input  logic [PTR_SEL_W-1:0] ptrSel,
  output ctrlStrobes_t         ctl
);

  localparam logic [PTR_SEL_W:0] PTR_LIMIT = (PTR_SEL_W+1)'(NUM_PTRS);
  localparam logic [1:0]         STK_IDX   = 2'(STK_PTR);

  logic selOk;
  assign selOk = ({1'b0, ptrSel} < PTR_LIMIT);

  always_comb begin
    ctl           = '0;
    ctl.offSel    = OFF_NONE;
    ctl.nextSel   = NX_IMM;
    ctl.ptrIdx    = 2'(ptrSel);
    if (opValid) begin
      case (opCode)
        OP_DIRECT: begin
          ctl.accEn     = 1'b1;
          ctl.directSel = 1'b1;
        end
        OP_IND: begin
          ctl.accEn = selOk;
        end
        OP_POSTINC: begin
          ctl.accEn   = selOk;
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_INC;
        end
        OP_POSTDEC: begin
          ctl.accEn   = selOk;
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_DEC;
        end
        OP_PREINC: begin
          ctl.accEn   = selOk;
          ctl.offSel  = OFF_ONE;
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_INC;
        end
        OP_WINDEX: begin
          ctl.accEn  = selOk;
          ctl.offSel = OFF_W;
        end
        OP_LDPTR: begin
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_IMM;
        end
        OP_ADDPTR: begin
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_ADD;
        end
        OP_SUBPTR: begin
          ctl.ptrWr   = selOk;
          ctl.nextSel = NX_SUB;
        end
        OP_STKREL: begin
          ctl.accEn  = 1'b1;
          ctl.ptrIdx = STK_IDX;
          ctl.offSel = OFF_IMM;
        end
        OP_PUSHLIT: begin
          ctl.accEn   = 1'b1;
          ctl.ptrIdx  = STK_IDX;
          ctl.ptrWr   = 1'b1;
          ctl.nextSel = NX_DEC;
        end
        OP_LDBANK: begin
          ctl.bankWr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!ctl.accEn && !ctl.ptrWr && !ctl.bankWr)); // R14

  AST_BADSEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !selOk && (opCode inside {OP_IND, OP_POSTINC, OP_POSTDEC,
      OP_PREINC, OP_WINDEX, OP_LDPTR, OP_ADDPTR, OP_SUBPTR}))
      |-> (!ctl.accEn && !ctl.ptrWr)); // R14

endmodule

// File: rtl/dagDatapath.sv
module dagDatapath
  import dagPkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                FILE_W    = 8,
  parameter int                NUM_PTRS  = 3,
  parameter int                PTR_SEL_W = 2,
  parameter int                STK_OFF_W = 7,
  parameter int                ADJ_W     = 6,
  parameter logic [FILE_W-1:0] SPLIT     = 8'h60
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         ctl,
  input  logic                 bankedSel,
  input  logic [FILE_W-1:0]    fileAddr,
  input  logic [ADDR_W-1:0]    imm,
  input  logic [FILE_W-1:0]    wReg,
  input  logic [PTR_SEL_W-1:0] ptrRdSel,
  output logic [ADDR_W-1:0]    dataAddr,
  output logic [FILE_W-1:0]    ptrRdHi,
  output logic [FILE_W-1:0]    ptrRdLo,
  output logic [ADDR_W-FILE_W-1:0] bankOut
);

  localparam int HI_W  = ADDR_W - FILE_W;
  localparam int PAD_W = 2*FILE_W - ADDR_W;

  logic [ADDR_W-1:0] ptrQ [NUM_PTRS];
  logic [HI_W-1:0]   bankQ;
  logic [ADDR_W-1:0] basePtr;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] ptrAddr;
  logic [ADDR_W-1:0] dirAddr;
  logic [ADDR_W-1:0] nextPtr;
  logic [ADDR_W-1:0] rdPtr;

  assign basePtr = ptrQ[ctl.ptrIdx];

  always_comb begin
    case (ctl.offSel)
      OFF_ONE: offset = ADDR_W'(1);
      OFF_W:   offset = {{HI_W{wReg[FILE_W-1]}}, wReg};
      OFF_IMM: offset = {{(ADDR_W-STK_OFF_W){1'b0}}, imm[STK_OFF_W-1:0]};
      default: offset = '0;
    endcase
  end

  assign ptrAddr = basePtr + offset;

  always_comb begin
    if (bankedSel)               dirAddr = {bankQ, fileAddr};
    else if (fileAddr >= SPLIT)  dirAddr = {{HI_W{1'b1}}, fileAddr};
    else                         dirAddr = {{HI_W{1'b0}}, fileAddr};
  end

  always_comb begin
    if (!ctl.accEn)        dataAddr = '0;
    else if (ctl.directSel) dataAddr = dirAddr;
    else                   dataAddr = ptrAddr;
  end

  always_comb begin
    case (ctl.nextSel)
      NX_INC:  nextPtr = basePtr + ADDR_W'(1);
      NX_DEC:  nextPtr = basePtr - ADDR_W'(1);
      NX_ADD:  nextPtr = basePtr + {{(ADDR_W-ADJ_W){1'b0}}, imm[ADJ_W-1:0]};
      NX_SUB:  nextPtr = basePtr - {{(ADDR_W-ADJ_W){1'b0}}, imm[ADJ_W-1:0]};
      default: nextPtr = imm;
    endcase
  end

  for (genvar gi = 0; gi < NUM_PTRS; gi++) begin : gPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ptrQ[gi] <= '0;
      else if (ctl.ptrWr && (ctl.ptrIdx == 2'(gi)))
        ptrQ[gi] <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bankQ <= '0;
    else if (ctl.bankWr) bankQ <= imm[HI_W-1:0];
  end

  always_comb begin
    rdPtr = '0;
    for (int i = 0; i < NUM_PTRS; i++)
      if (ptrRdSel == PTR_SEL_W'(i)) rdPtr = ptrQ[i];
  end

  assign ptrRdHi = {{PAD_W{1'b0}}, rdPtr[ADDR_W-1:FILE_W]};
  assign ptrRdLo = rdPtr[FILE_W-1:0];
  assign bankOut = bankQ;

  AST_BANKED_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && ctl.directSel && bankedSel)
      |-> (dataAddr[ADDR_W-1:FILE_W] == bankQ)); // R2

  AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && ctl.directSel && !bankedSel && fileAddr < SPLIT)
      |-> (dataAddr[ADDR_W-1:FILE_W] == '0)); // R3

  AST_PTR0_INC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ptrWr && ctl.ptrIdx == 2'd0 && ctl.nextSel == NX_INC)
      |=> (ptrQ[0] == $past(ptrQ[0]) + ADDR_W'(1))); // R5

  AST_PTR0_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && !ctl.ptrWr && ctl.ptrIdx == 2'd0)
      |=> $stable(ptrQ[0])); // R4

  AST_STK_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ptrWr && ctl.ptrIdx == 2'd2 && ctl.nextSel == NX_DEC)
      |=> (ptrQ[2] == $past(ptrQ[2]) - ADDR_W'(1))); // R11

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bankWr |=> (bankOut == $past(imm[HI_W-1:0]))); // R12

endmodule

// File: rtl/dataAddrGen.sv
module dataAddrGen
  import dagPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int FILE_W    = 8,
  parameter int NUM_PTRS  = 3,
  parameter int PTR_SEL_W = 2,
  parameter int STK_OFF_W = 7,
  parameter int ADJ_W     = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic [3:0]               opCode,
  input  logic [PTR_SEL_W-1:0]     ptrSel,
  input  logic                     bankedSel,
  input  logic [FILE_W-1:0]        fileAddr,
  input  logic [ADDR_W-1:0]        imm,
  input  logic [FILE_W-1:0]        wReg,
  input  logic [PTR_SEL_W-1:0]     ptrRdSel,
  output logic                     addrValid,
  output logic [ADDR_W-1:0]        dataAddr,
  output logic [FILE_W-1:0]        ptrRdHi,
  output logic [FILE_W-1:0]        ptrRdLo,
  output logic [ADDR_W-FILE_W-1:0] bankOut
);

  ctrlStrobes_t ctl;

  dagCtrl #(
    .NUM_PTRS (NUM_PTRS),
    .PTR_SEL_W(PTR_SEL_W),
    .STK_PTR  (2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opCode (opCode),
    .ptrSel (ptrSel),
    .ctl    (ctl)
  );

  dagDatapath #(
    .ADDR_W   (ADDR_W),
    .FILE_W   (FILE_W),
    .NUM_PTRS (NUM_PTRS),
    .PTR_SEL_W(PTR_SEL_W),
    .STK_OFF_W(STK_OFF_W),
    .ADJ_W    (ADJ_W),
    .SPLIT    (8'h60)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bankedSel(bankedSel),
    .fileAddr (fileAddr),
    .imm      (imm),
    .wReg     (wReg),
    .ptrRdSel (ptrRdSel),
    .dataAddr (dataAddr),
    .ptrRdHi  (ptrRdHi),
    .ptrRdLo  (ptrRdLo),
    .bankOut  (bankOut)
  );

  assign addrValid = ctl.accEn;

endmodule

// File: tb/dataAddrGen_tb.sv
module dataAddrGen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  ptrSel = '0;
  logic        bankedSel = 1'b0;
  logic [7:0]  fileAddr = '0;
  logic [11:0] imm = '0;
  logic [7:0]  wReg = '0;
  logic [1:0]  ptrRdSel = '0;
  logic        addrValid;
  logic [11:0] dataAddr;
  logic [7:0]  ptrRdHi;
  logic [7:0]  ptrRdLo;
  logic [3:0]  bankOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dataAddrGen u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .ptrSel(ptrSel), .bankedSel(bankedSel), .fileAddr(fileAddr),
    .imm(imm), .wReg(wReg), .ptrRdSel(ptrRdSel), .addrValid(addrValid),
    .dataAddr(dataAddr), .ptrRdHi(ptrRdHi), .ptrRdLo(ptrRdLo),
    .bankOut(bankOut)
  );

  // {op, sel, banked, file, imm, w, expValid, expAddr}
  localparam int NV = 26;
  localparam logic [47:0] VEC [NV] = '{
    {4'd12, 2'd0, 1'b0, 8'h00, 12'h0F5, 8'h00, 1'b0, 12'h000}, // R12 bank=5
    {4'd1,  2'd0, 1'b1, 8'h34, 12'h000, 8'h00, 1'b1, 12'h534}, // R2
    {4'd1,  2'd0, 1'b0, 8'h60, 12'h000, 8'h00, 1'b1, 12'hF60}, // R3
    {4'd1,  2'd0, 1'b0, 8'h5F, 12'h000, 8'h00, 1'b1, 12'h05F}, // R3
    {4'd7,  2'd0, 1'b0, 8'h00, 12'h123, 8'h00, 1'b0, 12'h000}, // R8
    {4'd2,  2'd0, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h123}, // R4
    {4'd3,  2'd0, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h123}, // R5
    {4'd2,  2'd0, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h124}, // R5
    {4'd4,  2'd0, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h124}, // R5
    {4'd5,  2'd0, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h124}, // R6
    {4'd6,  2'd0, 1'b0, 8'h00, 12'h000, 8'hFE, 1'b1, 12'h122}, // R7
    {4'd6,  2'd0, 1'b0, 8'h00, 12'h000, 8'h10, 1'b1, 12'h134}, // R7
    {4'd7,  2'd2, 1'b0, 8'h00, 12'h200, 8'h00, 1'b0, 12'h000}, // R8
    {4'd10, 2'd3, 1'b0, 8'h00, 12'hFFF, 8'h00, 1'b1, 12'h27F}, // R10
    {4'd11, 2'd3, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h200}, // R11
    {4'd2,  2'd2, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h1FF}, // R11
    {4'd8,  2'd1, 1'b0, 8'h00, 12'hFFF, 8'h00, 1'b0, 12'h000}, // R9
    {4'd2,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h03F}, // R9
    {4'd9,  2'd1, 1'b0, 8'h00, 12'h03F, 8'h00, 1'b0, 12'h000}, // R9
    {4'd2,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h000}, // R9
    {4'd9,  2'd1, 1'b0, 8'h00, 12'h001, 8'h00, 1'b0, 12'h000}, // R13
    {4'd2,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'hFFF}, // R13
    {4'd3,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'hFFF}, // R13
    {4'd2,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h000}, // R13
    {4'd3,  2'd3, 1'b0, 8'h00, 12'h000, 8'h00, 1'b0, 12'h000}, // R14
    {4'd2,  2'd1, 1'b0, 8'h00, 12'h000, 8'h00, 1'b1, 12'h000}  // R14
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [1:0] sel, input logic bk,
                       input logic [7:0] f, input logic [11:0] im, input logic [7:0] w);
    opValid = 1'b1; opCode = op; ptrSel = sel; bankedSel = bk;
    fileAddr = f; imm = im; wReg = w;
  endtask

  task automatic idle();
    opValid = 1'b0; opCode = 4'd0;
  endtask

  task automatic readPtr(input logic [1:0] sel, input string req, input logic [11:0] exp);
    @(negedge clk);
    idle();
    ptrRdSel = sel;
    #1;
    check(req, {ptrRdHi, ptrRdLo}, {4'h0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid", {15'd0, addrValid}, 16'd0);
    check("R1 addr", {4'd0, dataAddr}, 16'd0);
    check("R1 bank", {12'd0, bankOut}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < 3; p++) readPtr(2'(p), "R1 ptr", 12'h000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][47:44], VEC[i][43:42], VEC[i][41], VEC[i][40:33],
            VEC[i][32:21], VEC[i][20:13]);
      #1;
      check($sformatf("vector %0d valid", i), {15'd0, addrValid}, {15'd0, VEC[i][12]});
      check($sformatf("vector %0d addr", i), {4'd0, dataAddr}, {4'd0, VEC[i][11:0]});
    end

    // R8/R12 readback of state built by the table
    readPtr(2'd0, "R8 ptr0", 12'h124);
    readPtr(2'd2, "R8 ptr2", 12'h1FF);
    readPtr(2'd3, "R8 ptr3 none", 12'h000);
    check("R12 bank", {12'd0, bankOut}, 16'd5);

    // R8 full-width load, high byte padding
    @(negedge clk); drive(4'd7, 2'd1, 1'b0, 8'h00, 12'hABC, 8'h00);
    readPtr(2'd1, "R8 load", 12'hABC);

    // R14 opValid low with a post-increment opcode
    @(negedge clk);
    drive(4'd3, 2'd1, 1'b0, 8'h00, 12'h000, 8'h00);
    opValid = 1'b0;
    #1;
    check("R14 idle valid", {15'd0, addrValid}, 16'd0);
    check("R14 idle addr", {4'd0, dataAddr}, 16'd0);
    readPtr(2'd1, "R14 idle ptr", 12'hABC);

    // R14 load with bad index leaves pointers untouched
    @(negedge clk); drive(4'd7, 2'd3, 1'b0, 8'h00, 12'h777, 8'h00);
    for (int p = 0; p < 3; p++)
      readPtr(2'(p), "R14 badsel ptr", (p == 0) ? 12'h124 : (p == 1) ? 12'hABC : 12'h1FF);

    // R7/R13 W = -128 from 0 wraps
    @(negedge clk); drive(4'd7, 2'd0, 1'b0, 8'h00, 12'h000, 8'h00);
    @(negedge clk); drive(4'd6, 2'd0, 1'b0, 8'h00, 12'h000, 8'h80);
    #1;
    check("R7 negative W wrap", {4'd0, dataAddr}, 16'h0F80);
    readPtr(2'd0, "R7 ptr unchanged", 12'h000);

    // R6/R13 pre-increment at 0xFFF
    @(negedge clk); drive(4'd7, 2'd2, 1'b0, 8'h00, 12'hFFF, 8'h00);
    @(negedge clk); drive(4'd5, 2'd2, 1'b0, 8'h00, 12'h000, 8'h00);
    #1;
    check("R6 preinc wrap addr", {4'd0, dataAddr}, 16'h0000);
    readPtr(2'd2, "R6 preinc wrap ptr", 12'h000);

    // R11/R13 push from 0 wraps to 0xFFF
    @(negedge clk); drive(4'd11, 2'd0, 1'b0, 8'h00, 12'h0AA, 8'h00);
    #1;
    check("R11 push addr", {4'd0, dataAddr}, 16'h0000);
    readPtr(2'd2, "R11 push wrap", 12'hFFF);

    // R10/R13 stack-relative wraps past 0xFFF
    @(negedge clk); drive(4'd10, 2'd0, 1'b0, 8'h00, 12'h002, 8'h00);
    #1;
    check("R10 stack wrap", {4'd0, dataAddr}, 16'h0001);
    readPtr(2'd2, "R10 ptr2 unchanged", 12'hFFF);

    // R2 bank reload to 0xF, banked low address
    @(negedge clk); drive(4'd12, 2'd0, 1'b0, 8'h00, 12'h00F, 8'h00);
    @(negedge clk); drive(4'd1, 2'd0, 1'b1, 8'h05, 12'h000, 8'h00);
    #1;
    check("R2 banked F", {4'd0, dataAddr}, 16'h0F05);

    @(negedge clk); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule